// File: doc/BRIEF.md
# Sixteen-Slot Periodic Wakeup Timer Bank

This block holds sixteen independent interval timers that share a single wakeup path into a task scheduler. Software, or a sequencing engine, programs a timer by presenting a 16-bit command word together with either a load strobe or an add strobe. The word packs a 4-bit state, an 8-bit count and a 4-bit slot number. All timers advance on a common coarse tick, which is one pulse every `TICK_CYCLES` clock cycles (64 by default). A count of N therefore means roughly N × 64 cycles.

A timer is expired while its internal count is negative. Expired timers compete for one shared wakeup register, and the highest slot number wins. The register offers the winner's slot number and state on a valid/ready pair. It keeps offering them until the consumer accepts, however long that takes. An accepted timer is parked and does not ask again until it is rewritten.

The add strobe re-arms a periodic timer relative to its previous expiry, so late servicing does not shift later expiries. If an expired timer cannot reach the wakeup register, its count keeps falling. After 128 ticks the count wraps positive and the request drops. After another 128 ticks it turns negative and the request returns. Commands must be spaced at least `MIN_GAP` cycles apart (7 by default); a command that arrives sooner raises a one-cycle error flag.

Top module: `tmr_wake_array`

## Requirements
- R1: The command word is split as state = bits [15:12], count = bits [11:4], slot = bits [3:0]. A command acts only on the slot it names.
- R2: A load with count N (state top bit clear) makes the slot expire after N ticks. Its wakeup appears no earlier than (N-1)×TICK_CYCLES cycles and no later than N×TICK_CYCLES+2 cycles after the command edge.
- R3: A slot whose state has bit [3] set is disabled. It does not count down and never produces a wakeup.
- R4: An add adds N to the slot's current remaining count, which has kept falling since expiry. The next expiry is therefore N ticks after the previous one, not N ticks after the add. The add also writes the state and unparks the slot.
- R5: While wake_valid is high and wake_ready is low, wake_valid, wake_slot and wake_state hold steady. wake_slot/wake_state carry the captured slot number and that slot's state at capture time.
- R6: A cycle with wake_valid and wake_ready high frees the register. On the next cycle another pending timer may already be presented. The accepted slot is not presented again until a load or add rewrites it.
- R7: When several expired timers wait for a free register, the one with the highest slot number is presented first.
- R8: An expired timer that is never captured stops requesting once 128 ticks have passed since expiry. It requests again after a further 128 ticks.
- R9: A command arriving fewer than MIN_GAP cycles after the previous command raises proto_err for exactly the following cycle. A spacing of exactly MIN_GAP raises nothing. The command still takes effect.
- R10: Load and add asserted together apply the load only, and raise proto_err.
- R11: After reset, wake_valid and proto_err are low and every slot is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_load | input | 1 | Load strobe: replace state and count of the addressed slot |
| cmd_add | input | 1 | Add strobe: write state, add count to the addressed slot |
| cmd_word | input | 16 | Packed command {state[3:0], count[7:0], slot[3:0]} |
| wake_valid | output | 1 | A captured expired timer is being offered |
| wake_ready | input | 1 | Consumer accepts the offered wakeup |
| wake_slot | output | 4 | Slot number of the offered wakeup |
| wake_state | output | 4 | State of that slot when it was captured |
| proto_err | output | 1 | One-cycle flag: command spacing violated or both strobes set |

## Verification
A wrong per-slot count shows up as a wakeup that arrives outside its one-tick window. The same fault can also skew a late add, so the gap between an add and the wakeup it causes is measured against both the add rule and the load rule. A stuck park bit or a bad arbitration mask shows up on the cycle right after an acknowledge, when the wrong slot, or the accepted slot again, is presented. Wrap errors only appear after 128 or 256 ticks, so one timer is deliberately left blocked long enough to cover both edges. Spacing faults reach proto_err on the cycle right after the offending command, and are checked at spacings of 3, 6 and 7 cycles.

// File: rtl/tmr_wake_pkg.sv
package tmr_wake_pkg;
  localparam int NSLOT   = 16;
  localparam int SLOT_W  = $clog2(NSLOT);
  localparam int STATE_W = 4;
  localparam int COUNT_W = 8;
  localparam int WORD_W  = STATE_W + COUNT_W + SLOT_W;

  // Reset value of a slot's state: top bit set means disabled
  localparam logic [STATE_W-1:0] STATE_OFF = {1'b1, {(STATE_W-1){1'b0}}};

  typedef struct packed {
    logic [STATE_W-1:0] state;
    logic [COUNT_W-1:0] count;
    logic [SLOT_W-1:0]  slot;
  } cmd_word_t;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_wake_pkg::*;
#(
  parameter int MIN_GAP = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_load,
  input  logic               cmd_add,
  input  logic [WORD_W-1:0]  cmd_word,
  output logic [NSLOT-1:0]   wr_load,
  output logic [NSLOT-1:0]   wr_add,
  output logic [STATE_W-1:0] wr_state,
  output logic [COUNT_W-1:0] wr_count,
  output logic               proto_err
);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP);

  cmd_word_t        word;
  logic             any_cmd;
  logic             do_add;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             err_q, err_d;

  assign word     = cmd_word_t'(cmd_word);
  assign wr_state = word.state;
  assign wr_count = word.count;
  assign any_cmd  = cmd_load | cmd_add;
  assign do_add   = cmd_add & ~cmd_load;

  for (genvar s = 0; s < NSLOT; s++) begin : g_sel
    assign wr_load[s] = cmd_load & (word.slot == SLOT_W'(s));
    assign wr_add[s]  = do_add   & (word.slot == SLOT_W'(s));
  end

  always_comb begin
    gap_d = gap_q;
    if (any_cmd)            gap_d = GAP_W'(1);
    else if (gap_q < GAP_MAX) gap_d = gap_q + GAP_W'(1);
    err_d = (any_cmd & (gap_q < GAP_MAX)) | (cmd_load & cmd_add);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= GAP_MAX;
      err_q <= 1'b0;
    end else begin
      gap_q <= gap_d;
      err_q <= err_d;
    end
  end

  assign proto_err = err_q;
endmodule

// File: rtl/tmr_slot.sv
module tmr_slot
  import tmr_wake_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               wr_load,
  input  logic               wr_add,
  input  logic [STATE_W-1:0] wr_state,
  input  logic [COUNT_W-1:0] wr_count,
  input  logic               capture,
  output logic               req,
  output logic [STATE_W-1:0] state
);
  logic [STATE_W-1:0] state_q, state_d;
  logic [COUNT_W-1:0] cnt_q, cnt_d;
  logic               park_q, park_d;
  logic               enabled;
  logic               step;
  logic               upd_en;

  assign enabled = ~state_q[STATE_W-1];
  assign step    = tick & enabled;
  assign upd_en  = wr_load | wr_add | step | capture;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    park_d  = park_q;
    if (wr_load) begin
      state_d = wr_state;
      cnt_d   = wr_count - COUNT_W'(1);
      park_d  = 1'b0;
    end else if (wr_add) begin
      state_d = wr_state;
      cnt_d   = cnt_q + wr_count - COUNT_W'(step);
      park_d  = 1'b0;
    end else if (step) begin
      cnt_d   = cnt_q - COUNT_W'(1);
    end
    if (capture) park_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STATE_OFF;
      cnt_q   <= '0;
      park_q  <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      park_q  <= park_d;
    end
  end

  assign req   = enabled & cnt_q[COUNT_W-1] & ~park_q;
  assign state = state_q;
endmodule

// File: rtl/tmr_wake_arb.sv
module tmr_wake_arb
  import tmr_wake_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NSLOT-1:0]                req,
  input  logic [NSLOT-1:0]                busy,
  input  logic [NSLOT-1:0][STATE_W-1:0]   slot_state,
  input  logic                            wake_ready,
  output logic [NSLOT-1:0]                capture,
  output logic                            wake_valid,
  output logic [SLOT_W-1:0]               wake_slot,
  output logic [STATE_W-1:0]              wake_state
);
  logic [NSLOT-1:0]   cand;
  logic               any;
  logic [SLOT_W-1:0]  win;
  logic               free;
  logic               valid_q, valid_d;
  logic [SLOT_W-1:0]  slot_q, slot_d;
  logic [STATE_W-1:0] st_q, st_d;
  logic               reg_en;

  assign cand = req & ~busy;
  assign free = ~valid_q | wake_ready;

  // Highest index wins: later iterations overwrite earlier ones
  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (cand[i]) begin
        any = 1'b1;
        win = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    slot_d  = slot_q;
    st_d    = st_q;
    capture = '0;
    if (free) begin
      valid_d = any;
      if (any) begin
        slot_d       = win;
        st_d         = slot_state[win];
        capture[win] = 1'b1;
      end
    end
  end

  assign reg_en = free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      slot_q  <= '0;
      st_q    <= '0;
    end else if (reg_en) begin
      valid_q <= valid_d;
      slot_q  <= slot_d;
      st_q    <= st_d;
    end
  end

  assign wake_valid = valid_q;
  assign wake_slot  = slot_q;
  assign wake_state = st_q;
endmodule

// File: rtl/tmr_wake_array.sv
module tmr_wake_array
  import tmr_wake_pkg::*;
#(
  parameter int TICK_CYCLES = 64,
  parameter int MIN_GAP     = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_load,
  input  logic               cmd_add,
  input  logic [WORD_W-1:0]  cmd_word,
  output logic               wake_valid,
  input  logic               wake_ready,
  output logic [SLOT_W-1:0]  wake_slot,
  output logic [STATE_W-1:0] wake_state,
  output logic               proto_err
);
  localparam int PRE_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0]              pre_q, pre_d;
  logic                          tick;
  logic [NSLOT-1:0]              wr_load, wr_add, capture, req;
  logic [STATE_W-1:0]            wr_state;
  logic [COUNT_W-1:0]            wr_count;
  logic [NSLOT-1:0][STATE_W-1:0] slot_state;

  assign tick  = (pre_q == PRE_LAST);
  assign pre_d = tick ? '0 : pre_q + PRE_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  tmr_cmd_decode #(.MIN_GAP(MIN_GAP)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_load  (cmd_load),
    .cmd_add   (cmd_add),
    .cmd_word  (cmd_word),
    .wr_load   (wr_load),
    .wr_add    (wr_add),
    .wr_state  (wr_state),
    .wr_count  (wr_count),
    .proto_err (proto_err)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    tmr_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .wr_load  (wr_load[s]),
      .wr_add   (wr_add[s]),
      .wr_state (wr_state),
      .wr_count (wr_count),
      .capture  (capture[s]),
      .req      (req[s]),
      .state    (slot_state[s])
    );
  end

  tmr_wake_arb u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .busy       (wr_load | wr_add),
    .slot_state (slot_state),
    .wake_ready (wake_ready),
    .capture    (capture),
    .wake_valid (wake_valid),
    .wake_slot  (wake_slot),
    .wake_state (wake_state)
  );
endmodule

// File: rtl/tmr_wake_array_chk.sv
module tmr_wake_array_chk
  import tmr_wake_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_load,
  input logic               cmd_add,
  input logic [WORD_W-1:0]  cmd_word,
  input logic               wake_valid,
  input logic               wake_ready,
  input logic [SLOT_W-1:0]  wake_slot,
  input logic [STATE_W-1:0] wake_state,
  input logic               proto_err
);
  logic any_cmd;
  assign any_cmd = cmd_load | cmd_add;

  AST_WAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid && !wake_ready |=> wake_valid && $stable(wake_slot) && $stable(wake_state)); // R5

  AST_ACK_PARKS: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid && wake_ready |=> !wake_valid || (wake_slot != $past(wake_slot))); // R6

  AST_WAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> !wake_state[STATE_W-1]); // R3

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    any_cmd && $past(any_cmd) |=> proto_err); // R9

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(any_cmd)); // R9

  AST_BOTH_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load && cmd_add |=> proto_err); // R10
endmodule

bind tmr_wake_array tmr_wake_array_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_load   (cmd_load),
  .cmd_add    (cmd_add),
  .cmd_word   (cmd_word),
  .wake_valid (wake_valid),
  .wake_ready (wake_ready),
  .wake_slot  (wake_slot),
  .wake_state (wake_state),
  .proto_err  (proto_err)
);

// File: tb/tb_tmr_wake_array.sv
`timescale 1ns/1ps
module tb_tmr_wake_array;
  localparam int T = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_load = 1'b0;
  logic        cmd_add = 1'b0;
  logic [15:0] cmd_word = '0;
  logic        wake_ready = 1'b0;
  logic        wake_valid;
  logic [3:0]  wake_slot;
  logic [3:0]  wake_state;
  logic        proto_err;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tmr_wake_array #(.TICK_CYCLES(T), .MIN_GAP(7)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_load(cmd_load), .cmd_add(cmd_add),
    .cmd_word(cmd_word), .wake_valid(wake_valid), .wake_ready(wake_ready),
    .wake_slot(wake_slot), .wake_state(wake_state), .proto_err(proto_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One command, then 7 idle cycles so spacing is always legal
  task automatic issue(input bit add, input logic [15:0] w);
    @(negedge clk);
    cmd_load = !add; cmd_add = add; cmd_word = w;
    @(negedge clk);
    cmd_load = 1'b0; cmd_add = 1'b0;
    waitn(6);
  endtask

  task automatic ack();
    @(negedge clk); wake_ready = 1'b1;
    @(negedge clk); wake_ready = 1'b0;
  endtask

  task automatic t_reset();
    check("R11", "valid after reset", wake_valid, 0);
    check("R11", "err after reset", proto_err, 0);
    waitn(3*T);
    check("R11", "slots idle after reset", wake_valid, 0);
  endtask

  task automatic t_load_expire();
    issue(0, 16'h50AF);                 // R1: state 5, count 10, slot 15
    waitn(9*T - 12);
    check("R2", "no wake before window", wake_valid, 0);
    waitn(80);
    check("R2", "wake after 10 ticks", wake_valid, 1);
    check("R1", "slot field", wake_slot, 15);
    check("R5", "state carried", wake_state, 5);
    waitn(100);
    check("R5", "held while not ready", wake_valid, 1);
    check("R5", "slot held", wake_slot, 15);
    ack();
    check("R6", "freed on ack", wake_valid, 0);
    waitn(3*T);
    check("R6", "accepted slot parked", wake_valid, 0);
  endtask

  task automatic t_priority();
    issue(0, 16'h301F);                 // slot 15 blocker, state 3
    waitn(3*T);
    check("R5", "blocker present", wake_slot, 15);
    check("R5", "blocker state", wake_state, 3);
    issue(0, 16'h5013);
    issue(0, 16'h5019);
    waitn(3*T);
    check("R5", "blocker still held", wake_slot, 15);
    @(negedge clk); wake_ready = 1'b1;
    @(negedge clk); wake_ready = 1'b0;
    check("R6", "handover next cycle", wake_valid, 1);
    check("R7", "highest slot first", wake_slot, 9);
    ack();
    check("R7", "lower slot second", wake_slot, 3);
    ack();
    check("R6", "empty after both", wake_valid, 0);
  endtask

  task automatic t_wrap();
    issue(0, 16'h301F);
    waitn(3*T);
    check("R8", "blocker present", wake_slot, 15);
    issue(0, 16'h5015);                 // slot 5 count 1, blocked
    waitn(150*T - 8);
    ack();
    check("R8", "request gone after wrap", wake_valid, 0);
    waitn(100*T);
    check("R8", "still quiet", wake_valid, 0);
    waitn(8*T);
    check("R8", "request back", wake_valid, 1);
    check("R8", "returning slot", wake_slot, 5);
    ack();
  endtask

  task automatic t_add();
    int waited = 0;
    issue(0, 16'h50AF);
    while (!wake_valid && waited < 800) begin
      @(negedge clk); waited++;
    end
    check("R2", "periodic first wake", wake_slot, 15);
    ack();
    waitn(5*T);
    issue(1, 16'h50AF);                 // add 10 ticks
    waitn(T - 8);
    check("R4", "add not immediate", wake_valid, 0);
    waitn(5*T + 10);
    check("R4", "add anchored to expiry", wake_valid, 1);
    check("R4", "add slot", wake_slot, 15);
    ack();
  endtask

  task automatic t_disable();
    issue(0, 16'h503F);
    issue(0, 16'h800F);
    waitn(6*T);
    check("R3", "disabled slot silent", wake_valid, 0);
    issue(0, 16'h503F);
    waitn(4*T + 4);
    check("R3", "re-enabled slot wakes", wake_valid, 1);
    ack();
  endtask

  task automatic t_proto();
    @(negedge clk); cmd_load = 1'b1; cmd_word = 16'h800E;
    @(negedge clk); cmd_load = 1'b0;
    check("R9", "legal spacing", proto_err, 0);
    waitn(2);
    cmd_load = 1'b1;                    // 3 cycles after previous
    @(negedge clk); cmd_load = 1'b0;
    check("R9", "spacing 3 flagged", proto_err, 1);
    @(negedge clk);
    check("R9", "single-cycle flag", proto_err, 0);
    waitn(5);
    cmd_load = 1'b1;                    // exactly 7
    @(negedge clk); cmd_load = 1'b0;
    check("R9", "spacing 7 accepted", proto_err, 0);
    waitn(5);
    cmd_load = 1'b1;                    // 6
    @(negedge clk); cmd_load = 1'b0;
    check("R9", "spacing 6 flagged", proto_err, 1);
    waitn(8);
    issue(0, 16'h87FE);                 // disabled, count 0x7F
    @(negedge clk); cmd_load = 1'b1; cmd_add = 1'b1; cmd_word = 16'h502E;
    @(negedge clk); cmd_load = 1'b0; cmd_add = 1'b0;
    check("R10", "both strobes flagged", proto_err, 1);
    waitn(8);
    check("R10", "load applied not add", wake_valid, 0);
    waitn(2*T);
    check("R10", "load count expiry", wake_valid, 1);
    check("R10", "slot 14", wake_slot, 14);
    ack();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    waitn(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load_expire();
    t_priority();
    t_wrap();
    t_add();
    t_disable();
    t_proto();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule